// File: doc/BRIEF.md
# Conditional Subroutine Call Unit

This unit carries out the control part of a conditional call instruction in a small DSP-style core. When an instruction is issued, the unit reads a 4-bit condition selector and tests it against the flags of the status register. If the test passes, the unit pushes the return address and the full status register onto an internal system stack as one two-half entry. It then loads the call target into the program counter. If the test fails, the program counter moves on by one word and the stack is left alone.

The target is either a 12-bit short immediate, zero-extended to the address width, or an effective address that an external address generator supplies. The instruction takes four cycles plus the wait cycles that the addressing mode adds. The unit raises `busy` for every cycle after the issue cycle and pulses `done` when the new program counter is visible. The instruction may not sit under a single-instruction repeat. An issue with `in_repeat` set is refused and flagged as illegal.

Top module: `cond_call_unit`

## Requirements
- R1: Status register bit positions are C=0, V=1, Z=2, N=3, U=4, E=5, L=6. Selector bit 3 inverts the test chosen by bits 2:0, which are: 0 C=0, 1 N^V=0, 2 Z=0, 3 N=0, 4 (Z|(~U&~E))=0, 5 E=0, 6 L=0, 7 (Z|(N^V))=0. So code 8 is C=1, code 12 is normalized, code 15 is Z|(N^V)=1, and so on.
- R2: A taken call increments `sp`. The new top entry holds the return address `pc_in+1+abs_form` in `top_pc` and `sr_in` in `top_sr`, and `pc_out` becomes the target.
- R3: A call that is not taken sets `pc_out` to `pc_in+1`, even when `abs_form` is set. `sp`, `top_pc` and `top_sr` stay unchanged.
- R4: With `short_mode`=1 the target is `short_imm` zero-extended to 16 bits. With `short_mode`=0 the target is `ea_addr`.
- R5: After an issue cycle, `busy` is high for exactly 3+`ea_wait` cycles. `done` is high for the one cycle that follows them. `pc_out` changes only in a cycle where `done` is high.
- R6: An issue with `in_repeat`=1 pulses `illegal` for one cycle and does not raise `busy`. `pc_out` and the stack are left as they were.
- R7: When a taken call finds the stack full (`sp`=15), `stack_err` sets and stays set until reset. The jump still happens, and `sp` and the top entry do not change.
- R8: After reset, `pc_out`, `sp`, `top_pc`, `top_sr`, `busy`, `done`, `illegal` and `stack_err` are all zero.
- R9: While `busy` is high, `start` is ignored. The instruction in flight finishes with the operands it latched at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the instruction (sampled only when idle) |
| in_repeat | input | 1 | The issue sits under a single-instruction repeat |
| cond_sel | input | 4 | Condition selector |
| sr_in | input | 16 | Current status register |
| pc_in | input | 16 | Address of the instruction |
| short_mode | input | 1 | Use the short immediate target |
| short_imm | input | 12 | Short target address |
| ea_addr | input | 16 | Effective address from the address generator |
| abs_form | input | 1 | The instruction carries an extension word |
| ea_wait | input | 2 | Extra cycles that the addressing mode adds |
| busy | output | 1 | Instruction in progress after its first cycle |
| done | output | 1 | One-cycle pulse when `pc_out` is updated |
| illegal | output | 1 | One-cycle pulse for a refused repeated issue |
| pc_out | output | 16 | Program counter |
| sp | output | 4 | Stack pointer (number of entries held) |
| top_pc | output | 16 | Return address in the top stack entry |
| top_sr | output | 16 | Status register in the top stack entry |
| stack_err | output | 1 | Sticky stack overflow flag |

## Verification
All sixteen selector codes are run against all 128 combinations of the seven flag bits. This separates each condition from its complement and from its neighbours. It also catches a swapped flag bit, a wrong polarity, or a wrong normalized or greater-than formula. Within the sweep, the short and absolute target forms and the four wait counts alternate. This shows whether the target source, the return address and the busy length follow their own inputs. Because runs of taken calls go past fifteen entries, the stack is also pushed into overflow. Directed cases then cover a refused repeated issue, a second issue while busy, and the all-ones short immediate.

// File: rtl/cond_call_unit.sv
module cond_call_unit #(
  parameter int AW     = 16,
  parameter int SRW    = 16,
  parameter int DEPTH  = 15,
  parameter int WAIT_W = 2,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_repeat,
  input  logic [3:0]        cond_sel,
  input  logic [SRW-1:0]    sr_in,
  input  logic [AW-1:0]     pc_in,
  input  logic              short_mode,
  input  logic [IMM_W-1:0]  short_imm,
  input  logic [AW-1:0]     ea_addr,
  input  logic              abs_form,
  input  logic [WAIT_W-1:0] ea_wait,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [AW-1:0]     pc_out,
  output logic [$clog2(DEPTH+1)-1:0] sp,
  output logic [AW-1:0]     top_pc,
  output logic [SRW-1:0]    top_sr,
  output logic              stack_err
);
  localparam int SP_W  = $clog2(DEPTH+1);
  localparam int CNT_W = WAIT_W + 2;
  localparam int C_B = 0, V_B = 1, Z_B = 2, N_B = 3, U_B = 4, E_B = 5, L_B = 6;

  logic              f_c, f_v, f_z, f_n, f_u, f_e, f_l;
  logic              base_ok, cond_ok;
  logic [CNT_W-1:0]  cnt;
  logic              taken_q;
  logic [AW-1:0]     tgt_q, ret_q, nt_q;
  logic [SRW-1:0]    sr_q;
  logic [AW+SRW-1:0] stk [DEPTH];
  logic              finish, full;
  logic [SP_W-1:0]   top_idx;

  assign f_c = sr_in[C_B];
  assign f_v = sr_in[V_B];
  assign f_z = sr_in[Z_B];
  assign f_n = sr_in[N_B];
  assign f_u = sr_in[U_B];
  assign f_e = sr_in[E_B];
  assign f_l = sr_in[L_B];

  always_comb begin
    case (cond_sel[2:0])
      3'd0:    base_ok = ~f_c;
      3'd1:    base_ok = ~(f_n ^ f_v);
      3'd2:    base_ok = ~f_z;
      3'd3:    base_ok = ~f_n;
      3'd4:    base_ok = ~(f_z | (~f_u & ~f_e));
      3'd5:    base_ok = ~f_e;
      3'd6:    base_ok = ~f_l;
      default: base_ok = ~(f_z | (f_n ^ f_v));
    endcase
  end
  assign cond_ok = base_ok ^ cond_sel[3];

  assign busy    = (cnt != '0);
  assign finish  = (cnt == CNT_W'(1));
  assign full    = (sp == SP_W'(DEPTH));
  assign top_idx = sp - SP_W'(1);
  assign top_pc  = (sp == '0) ? '0 : stk[top_idx][AW+SRW-1:SRW];
  assign top_sr  = (sp == '0) ? '0 : stk[top_idx][SRW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      pc_out    <= '0;
      sp        <= '0;
      stack_err <= 1'b0;
      taken_q   <= 1'b0;
      tgt_q     <= '0;
      ret_q     <= '0;
      nt_q      <= '0;
      sr_q      <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (in_repeat) begin
            illegal <= 1'b1;
          end else begin
            cnt     <= CNT_W'(3) + CNT_W'(ea_wait);
            taken_q <= cond_ok;
            tgt_q   <= short_mode ? AW'(short_imm) : ea_addr;
            ret_q   <= pc_in + AW'(1) + AW'(abs_form);
            nt_q    <= pc_in + AW'(1);
            sr_q    <= sr_in;
          end
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
        if (finish) begin
          done <= 1'b1;
          if (taken_q) begin
            pc_out <= tgt_q;
            if (full) stack_err <= 1'b1;
            else      sp <= sp + SP_W'(1);
          end else begin
            pc_out <= nt_q;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && finish && taken_q && !full)
      stk[sp[$clog2(DEPTH)-1:0]] <= {ret_q, sr_q};
  end
endmodule

module cond_call_unit_chk #(
  parameter int AW   = 16,
  parameter int SP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            illegal,
  input logic [AW-1:0]   pc_out,
  input logic [SP_W-1:0] sp,
  input logic            stack_err
);
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_pc_only_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc_out));
  p_sp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> (sp == $past(sp) + SP_W'(1)) && done);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stack_err) |-> stack_err);
  p_illegal_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !done);
endmodule

bind cond_call_unit cond_call_unit_chk #(.AW(AW), .SP_W($clog2(DEPTH+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
  .pc_out(pc_out), .sp(sp), .stack_err(stack_err));

// File: tb/sim_cond_call_unit.sv
module sim_cond_call_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, in_repeat = 1'b0, short_mode = 1'b0, abs_form = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic [15:0] sr_in = '0, pc_in = '0, ea_addr = '0;
  logic [11:0] short_imm = '0;
  logic [1:0]  ea_wait = '0;
  logic        busy, done, illegal, stack_err;
  logic [15:0] pc_out, top_pc, top_sr;
  logic [3:0]  sp;

  int errors = 0, checks = 0;
  int msp = 0;
  logic        merr = 1'b0;
  logic [15:0] mpc = '0;
  logic [15:0] mstk_pc [15];
  logic [15:0] mstk_sr [15];

  always #10 clk = ~clk;

  cond_call_unit u0 (.clk, .rst_n, .start, .in_repeat, .cond_sel, .sr_in, .pc_in,
    .short_mode, .short_imm, .ea_addr, .abs_form, .ea_wait, .busy, .done, .illegal,
    .pc_out, .sp, .top_pc, .top_sr, .stack_err);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_cond(input logic [3:0] code, input logic [15:0] s);
    logic c, v, z, n, u, e, l;
    {l, e, u, n, z, v, c} = s[6:0];
    case (code)
      4'd0:  return c == 1'b0;
      4'd8:  return c == 1'b1;
      4'd5:  return e == 1'b0;
      4'd13: return e == 1'b1;
      4'd10: return z == 1'b1;
      4'd2:  return z == 1'b0;
      4'd1:  return (n ^ v) == 1'b0;
      4'd9:  return (n ^ v) == 1'b1;
      4'd7:  return (z | (n ^ v)) == 1'b0;
      4'd15: return (z | (n ^ v)) == 1'b1;
      4'd6:  return l == 1'b0;
      4'd14: return l == 1'b1;
      4'd11: return n == 1'b1;
      4'd3:  return n == 1'b0;
      4'd12: return (z | (~u & ~e)) == 1'b1;
      default: return (z | (~u & ~e)) == 1'b0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    msp = 0; merr = 1'b0; mpc = '0;
  endtask

  task automatic run(input logic [3:0] code, input logic [15:0] s, input logic [15:0] pc,
                     input logic sm, input logic [11:0] imm, input logic [15:0] ea,
                     input logic ab, input logic [1:0] w, input bit poke);
    bit taken;
    logic [15:0] tgt, ret;
    int n;
    taken = model_cond(code, s);
    tgt = sm ? {4'h0, imm} : ea;
    ret = pc + 16'd1 + {15'd0, ab};
    @(negedge clk);
    cond_sel = code; sr_in = s; pc_in = pc; short_mode = sm; short_imm = imm;
    ea_addr = ea; abs_form = ab; ea_wait = w; in_repeat = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done) begin
      if (busy) n++;
      if (poke && n == 1) begin
        // R9: a second issue while busy must be ignored
        start = 1'b1; pc_in = ~pc; cond_sel = ~code; ea_addr = ~ea; short_imm = ~imm;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == 3 + int'(w), "R5 busy length", n, 3 + int'(w));
    if (taken) begin
      if (msp == 15) merr = 1'b1;
      else begin mstk_pc[msp] = ret; mstk_sr[msp] = s; msp++; end
      mpc = tgt;
    end else mpc = pc + 16'd1;
    chk(pc_out == mpc, taken ? "R2 R4 taken target" : "R3 not-taken pc", pc_out, mpc);
    chk(int'(sp) == msp, "R2 R3 R7 stack pointer", sp, msp);
    if (msp > 0) begin
      chk(top_pc == mstk_pc[msp-1], "R2 R3 top_pc", top_pc, mstk_pc[msp-1]);
      chk(top_sr == mstk_sr[msp-1], "R2 R3 top_sr", top_sr, mstk_sr[msp-1]);
    end
    chk(stack_err == merr, "R7 stack_err", stack_err, merr);
    @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R8 reset state
    chk(pc_out == 0 && sp == 0 && top_pc == 0 && top_sr == 0, "R8 reset regs",
        {pc_out, top_pc}, 0);
    chk(!busy && !done && !illegal && !stack_err, "R8 reset flags",
        {busy, done, illegal, stack_err}, 0);

    // R1 R2 R3 R4 R5 R7: all codes against all flag combinations
    for (int code = 0; code < 16; code++) begin
      do_reset();
      for (int f = 0; f < 128; f++) begin
        logic [15:0] pc, s;
        pc = {code[3:0], f[6:0], 5'd3};
        s  = {f[6:0], 2'b10, f[6:0]};
        run(code[3:0], s, pc, f[0] ^ code[0], pc[11:0] ^ 12'hA5A, ~pc ^ 16'h0F0F,
            f[2] ^ f[4], f[1:0] ^ f[4:3], 1'b0);
      end
    end

    // R4 all-ones short immediate, taken (code 0 with C=0)
    do_reset();
    run(4'd0, 16'h0000, 16'h8000, 1'b1, 12'hFFF, 16'hBEEF, 1'b1, 2'd3, 1'b0);
    chk(pc_out == 16'h0FFF, "R4 zero extension", pc_out, 16'h0FFF);
    chk(top_pc == 16'h8002, "R2 return past extension word", top_pc, 16'h8002);

    // R3 not taken with extension word still advances by one
    run(4'd8, 16'h0000, 16'h1234, 1'b0, 12'h0, 16'h4444, 1'b1, 2'd0, 1'b0);
    chk(pc_out == 16'h1235, "R3 abs not taken", pc_out, 16'h1235);

    // R9 issue during busy ignored
    run(4'd2, 16'h0000, 16'h2000, 1'b0, 12'h0, 16'h5555, 1'b0, 2'd2, 1'b1);
    @(negedge clk);
    chk(busy == 1'b0, "R9 no second instruction", busy, 0);

    // R6 repeated issue refused
    @(negedge clk);
    cond_sel = 4'd0; sr_in = '0; pc_in = 16'h7777; ea_addr = 16'h3333; short_mode = 1'b0;
    in_repeat = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; in_repeat = 1'b0;
    chk(illegal == 1'b1, "R6 illegal pulse", illegal, 1);
    chk(busy == 1'b0, "R6 no busy", busy, 0);
    @(negedge clk);
    chk(illegal == 1'b0, "R6 pulse length", illegal, 0);
    chk(pc_out == 16'h5555, "R6 pc unchanged", pc_out, 16'h5555);
    chk(int'(sp) == msp, "R6 sp unchanged", sp, msp);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule